// File: doc/BRIEF.md
# Warp Page-Lookup Coalescer

A single memory instruction from a warp gives one virtual address per lane, and in the worst case every lane names a different page. This block sits ahead of the translation lookaside buffer. It takes the whole address vector and an active-lane mask, removes the byte-offset bits, and finds the distinct virtual page numbers among the active lanes. It then sends one lookup per distinct page, one at a time, on a valid/ready stream.

The page size is a parameter. Its default is 256 bytes, so the page number is address bits [31:8].

A start strobe hands over the instruction. The block captures the addresses and the mask on that edge. Start is ignored while an earlier instruction is still draining.

The lookup stream obeys the usual valid/ready rules:
- A transfer happens on a rising edge where both valid and ready are high.
- valid never waits for ready.
- While valid is high and ready is low, the page number on the stream does not change.

When the last page has been accepted, a one-cycle done pulse reports the end of the instruction. The number of lookups issued is valid in that same cycle.

Top module: `warp_tlb_coalescer`

## Requirements
- R1: The page number sent is address bits [VA_W-1:log2(PAGE_BYTES)], i.e. bits [31:8] by default. Lanes whose addresses differ only in the low log2(PAGE_BYTES) bits share one lookup.
- R2: Every distinct page among the active lanes produces exactly one lookup, and the count reported with done equals the number of such pages.
- R3: When every active lane names a different page, the number of lookups equals the number of active lanes (at most LANES).
- R4: With all 8 lanes active and only lanes 0 and 1 on the same page, exactly 7 lookups are produced.
- R5: When all active lanes fall in one page, a single lookup is produced.
- R6: A lane whose mask bit is 0 never causes a lookup. Its page is not sent unless an active lane also names it.
- R7: Pages are sent in ascending order of the lowest-numbered active lane that names each page.
- R8: done is a one-cycle pulse. It is high in the cycle after the edge that transferred the last lookup, and lookup_count is valid in that cycle. A start that arrives before done has been asserted is ignored.
- R9: While lookup_valid is high and lookup_ready is low, lookup_valid stays high and lookup_vpn stays unchanged.
- R10: An all-zero lane mask produces no lookup. done rises two cycles after the start edge, with lookup_count equal to 0.
- R11: After reset, lookup_valid and done are low and lookup_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Strobe that captures a new instruction when the block is idle |
| lane_addr | input | LANES*VA_W | Per-lane virtual addresses, lane 0 in the low bits |
| lane_mask | input | LANES | Active-lane mask, bit i enables lane i |
| lookup_valid | output | 1 | A page lookup is offered |
| lookup_ready | input | 1 | The downstream consumer accepts the lookup |
| lookup_vpn | output | VA_W-log2(PAGE_BYTES) | Virtual page number of the offered lookup |
| lookup_count | output | $clog2(LANES+1) | Number of lookups issued, valid while done is high |
| done | output | 1 | One-cycle pulse at the end of an instruction |

## Verification
The first lookup is offered in the cycle after the start edge. Each later lookup is offered in the cycle after the edge that transferred the previous one. done and its count appear in the cycle after the last transfer, or two cycles after the start edge for an empty mask.

The bench drives inputs on the falling edge and reads outputs at that same falling edge. A lookup is recorded when valid and the ready value just driven are both high, because that pair completes at the next rising edge. Each recorded lookup is compared in order against a list of distinct pages that the bench derives from the lane addresses. The count is compared against the length of that list only in the cycle where done is seen, and the bench then confirms that done falls in the following cycle.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  // Drain controller states
  typedef enum logic {
    CO_IDLE = 1'b0,
    CO_EMIT = 1'b1
  } co_state_e;
endpackage

// File: rtl/wtc_vpn_slice.sv
// Strips the page-offset bits of every lane address.
module wtc_vpn_slice #(
  parameter int LANES = 8,
  parameter int VA_W  = 32,
  parameter int OFF_W = 8,
  localparam int VPN_W = VA_W - OFF_W
) (
  input  logic [LANES*VA_W-1:0]  addr_flat,
  output logic [LANES*VPN_W-1:0] vpn_flat
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign vpn_flat[g*VPN_W +: VPN_W] = addr_flat[g*VA_W + OFF_W +: VPN_W];
  end
endmodule

// File: rtl/wtc_first_lane.sv
// One-hot grant of the lowest-numbered requesting lane.
module wtc_first_lane #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0] req,
  output logic [LANES-1:0] grant
);
  logic [LANES-1:0] below;  // bit i: some lane < i requests

  assign below[0] = 1'b0;
  for (genvar g = 1; g < LANES; g++) begin : g_chain
    assign below[g] = below[g-1] | req[g-1];
  end
  assign grant = req & ~below;
endmodule

// File: rtl/wtc_page_match.sv
// Flags every lane whose page number equals the selected one.
module wtc_page_match #(
  parameter int LANES = 8,
  parameter int VPN_W = 24
) (
  input  logic [LANES*VPN_W-1:0] vpn_flat,
  input  logic [VPN_W-1:0]       sel_vpn,
  output logic [LANES-1:0]       hit
);
  for (genvar g = 0; g < LANES; g++) begin : g_cmp
    assign hit[g] = (vpn_flat[g*VPN_W +: VPN_W] == sel_vpn);
  end
endmodule

// File: rtl/warp_tlb_coalescer.sv
module warp_tlb_coalescer #(
  parameter int LANES      = 8,
  parameter int VA_W       = 32,
  parameter int PAGE_BYTES = 256,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int VPN_W = VA_W - OFF_W,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [LANES*VA_W-1:0]   lane_addr,
  input  logic [LANES-1:0]        lane_mask,
  output logic                    lookup_valid,
  input  logic                    lookup_ready,
  output logic [VPN_W-1:0]        lookup_vpn,
  output logic [CNT_W-1:0]        lookup_count,
  output logic                    done
);
  import wtc_pkg::*;

  co_state_e              state_q;
  logic [LANES*VPN_W-1:0] vpn_in;
  logic [LANES*VPN_W-1:0] vpn_q;
  logic [LANES-1:0]       pend_q;
  logic [LANES-1:0]       pend_nxt;
  logic [LANES-1:0]       grant;
  logic [LANES-1:0]       hit;
  logic [VPN_W-1:0]       sel_vpn;
  logic [CNT_W-1:0]       cnt_q;
  logic                   done_q;
  logic                   fire;
  logic                   busy;

  wtc_vpn_slice #(.LANES(LANES), .VA_W(VA_W), .OFF_W(OFF_W)) u_slice (
    .addr_flat (lane_addr),
    .vpn_flat  (vpn_in)
  );

  wtc_first_lane #(.LANES(LANES)) u_pick (
    .req   (pend_q),
    .grant (grant)
  );

  // One-hot mux of the page held by the granted lane
  always_comb begin
    sel_vpn = '0;
    for (int i = 0; i < LANES; i++) begin
      if (grant[i]) sel_vpn = sel_vpn | vpn_q[i*VPN_W +: VPN_W];
    end
  end

  wtc_page_match #(.LANES(LANES), .VPN_W(VPN_W)) u_match (
    .vpn_flat (vpn_q),
    .sel_vpn  (sel_vpn),
    .hit      (hit)
  );

  assign busy         = (state_q == CO_EMIT);
  assign lookup_valid = busy && (|pend_q);
  assign lookup_vpn   = sel_vpn;
  assign fire         = lookup_valid && lookup_ready;
  assign pend_nxt     = fire ? (pend_q & ~hit) : pend_q;
  assign lookup_count = cnt_q;
  assign done         = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CO_IDLE;
      vpn_q   <= '0;
      pend_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        CO_IDLE: begin
          if (start) begin
            vpn_q   <= vpn_in;
            pend_q  <= lane_mask;
            cnt_q   <= '0;
            state_q <= CO_EMIT;
          end
        end
        default: begin
          pend_q <= pend_nxt;
          if (fire) cnt_q <= cnt_q + CNT_W'(1);
          if (pend_nxt == '0) begin
            state_q <= CO_IDLE;
            done_q  <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/warp_tlb_coalescer_chk.sv
module warp_tlb_coalescer_chk #(
  parameter int LANES = 8,
  parameter int VPN_W = 24,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic [LANES-1:0] lane_mask,
  input logic             lookup_valid,
  input logic             lookup_ready,
  input logic [VPN_W-1:0] lookup_vpn,
  input logic [CNT_W-1:0] lookup_count,
  input logic             done
);
  logic [CNT_W-1:0] act_q;  // active lanes of the captured instruction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else if (start && !busy) act_q <= CNT_W'($countones(lane_mask));
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && !lookup_ready) |=> (lookup_valid && $stable(lookup_vpn)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_quiet_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !lookup_valid);

  assert_inactive_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lookup_count <= act_q));

  assert_width_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lookup_count <= CNT_W'(LANES)));

  assert_empty_no_lookup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && act_q == '0) |-> (lookup_count == '0));
endmodule

bind warp_tlb_coalescer warp_tlb_coalescer_chk #(
  .LANES(LANES), .VPN_W(VPN_W), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .lane_mask    (lane_mask),
  .lookup_valid (lookup_valid),
  .lookup_ready (lookup_ready),
  .lookup_vpn   (lookup_vpn),
  .lookup_count (lookup_count),
  .done         (done)
);

// File: tb/warp_tlb_coalescer_tb.sv
module warp_tlb_coalescer_tb_top;
  localparam int LANES = 8;
  localparam int VA_W  = 32;
  localparam int OFF   = 8;
  localparam int VPN_W = VA_W - OFF;
  localparam int CNT_W = 4;
  localparam int NV    = 7;

  // Stimulus table: lane 7 leftmost, lane 0 rightmost
  localparam logic [LANES*VA_W-1:0] V_ADDR [NV] = '{
    {32'h700, 32'h600, 32'h500, 32'h400, 32'h300, 32'h200, 32'h1F0, 32'h100},                  // R4
    {32'h401C, 32'h4018, 32'h4014, 32'h4010, 32'h400C, 32'h4008, 32'h4004, 32'h4000},          // R5
    {32'h210, 32'h3000_0010, 32'hFFFF_FF00, 32'h8100, 32'h77FF0, 32'hA0, 32'h2308, 32'h1000},  // R3
    {32'hC00, 32'hB00, 32'hA00, 32'h900, 32'h400, 32'h300, 32'h200, 32'h100},                  // R6
    {32'h5010, 32'h9000, 32'h1000, 32'h3008, 32'h1000, 32'h5004, 32'h3000, 32'h5000},          // R7
    {32'h12410, 32'h123FE, 32'h12301, 32'h124FF, 32'h12400, 32'h12380, 32'h123FF, 32'h12300},  // R1
    {32'h77FC, 32'hDD00, 32'h7780, 32'hCC00, 32'hBB00, 32'h7740, 32'hAA00, 32'h7700}           // R6
  };
  localparam logic [LANES-1:0] V_MASK [NV] = '{8'hFF, 8'hFF, 8'hFF, 8'h0F, 8'hFF, 8'hFF, 8'hA5};
  localparam int V_CNT [NV] = '{7, 1, 8, 4, 4, 2, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LANES*VA_W-1:0] lane_addr = '0;
  logic [LANES-1:0] lane_mask = '0;
  logic lookup_ready = 1'b0;
  logic lookup_valid;
  logic [VPN_W-1:0] lookup_vpn;
  logic [CNT_W-1:0] lookup_count;
  logic done;

  int n_chk = 0;
  int n_bad = 0;
  logic [VPN_W-1:0] exp_list [LANES];
  int exp_n;

  always #2.5 clk = ~clk;

  warp_tlb_coalescer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_addr(lane_addr),
    .lane_mask(lane_mask), .lookup_valid(lookup_valid), .lookup_ready(lookup_ready),
    .lookup_vpn(lookup_vpn), .lookup_count(lookup_count), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Ordered list of distinct pages of the active lanes
  task automatic ref_pages(input logic [LANES*VA_W-1:0] a, input logic [LANES-1:0] m);
    exp_n = 0;
    for (int i = 0; i < LANES; i++) begin
      if (m[i]) begin
        logic [VPN_W-1:0] p;
        bit seen;
        p = a[i*VA_W + OFF +: VPN_W];
        seen = 0;
        for (int j = 0; j < exp_n; j++) if (exp_list[j] == p) seen = 1;
        if (!seen) begin
          exp_list[exp_n] = p;
          exp_n++;
        end
      end
    end
  endtask

  // Start an instruction and drain it; ready follows a pattern chosen by seed
  task automatic run_instr(input string req, input logic [LANES*VA_W-1:0] a,
                           input logic [LANES-1:0] m, input int seed);
    int got = 0;
    int cyc = 0;
    bit fin = 0;
    ref_pages(a, m);
    @(negedge clk);
    lane_addr = a;
    lane_mask = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!fin && cyc < 200) begin
      lookup_ready = ((cyc + seed) % 3) != 0;
      if (done) begin
        check({req, " count"}, 32'(lookup_count), 32'(exp_n));
        check({req, " lookups seen"}, 32'(got), 32'(exp_n));
        fin = 1;
      end else if (lookup_valid && lookup_ready) begin
        check({req, " page order"}, 32'(lookup_vpn), (got < exp_n) ? 32'(exp_list[got]) : 32'hDEAD);
        got++;
      end
      if (!fin) begin
        @(negedge clk);
        cyc++;
      end
    end
    if (!fin) check({req, " done seen"}, 32'd0, 32'd1);
    lookup_ready = 1'b0;
    @(negedge clk);
    check("R8 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    #50000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset valid", 32'(lookup_valid), 32'd0);
    check("R11 reset done", 32'(done), 32'd0);
    check("R11 reset count", 32'(lookup_count), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_instr("R2 table", V_ADDR[v], V_MASK[v], v);
      check("R2 table count", 32'(exp_n), 32'(V_CNT[v]));
    end

    // R10: empty mask
    @(negedge clk);
    lane_addr = V_ADDR[0];
    lane_mask = '0;
    start = 1'b1;
    lookup_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 no lookup", 32'(lookup_valid), 32'd0);
    check("R10 no done yet", 32'(done), 32'd0);
    @(negedge clk);
    check("R10 done", 32'(done), 32'd1);
    check("R10 count zero", 32'(lookup_count), 32'd0);
    lookup_ready = 1'b0;

    // R9: back-pressure hold, then R8: start while busy is ignored
    @(negedge clk);
    lane_addr = V_ADDR[4];
    lane_mask = 8'hFF;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 valid offered", 32'(lookup_valid), 32'd1);
    check("R9 first page", 32'(lookup_vpn), 32'h50);
    repeat (4) @(negedge clk);
    check("R9 valid held", 32'(lookup_valid), 32'd1);
    check("R9 page held", 32'(lookup_vpn), 32'h50);
    lookup_ready = 1'b1;
    @(negedge clk);
    lookup_ready = 1'b0;
    check("R7 second page", 32'(lookup_vpn), 32'h30);
    lane_addr = V_ADDR[1];
    lane_mask = 8'h01;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 start ignored", 32'(lookup_vpn), 32'h30);
    lookup_ready = 1'b1;
    @(negedge clk);
    check("R8 stream kept", 32'(lookup_vpn), 32'h10);
    @(negedge clk);
    check("R8 stream kept", 32'(lookup_vpn), 32'h90);
    @(negedge clk);
    check("R8 done after ignored start", 32'(done), 32'd1);
    check("R8 count after ignored start", 32'(lookup_count), 32'd4);
    lookup_ready = 1'b0;
    @(negedge clk);
    check("R8 idle after ignored start", 32'(lookup_valid), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule